// File: doc/BRIEF.md
# Serial Receive Status Flag Controller

This block keeps the receive-side status of a serial receiver. A receive shifter reports each finished character with a one-cycle strobe, the received data and three error indications (noise, framing, parity). A line monitor reports an idle line with a one-cycle pulse, and the raw receive pin is watched for falling edges. The block holds the data of the latest accepted character and a set of sticky flags: receive-full, idle, overrun, noise, framing, parity and receive-edge.

Software sees the flags through a status read port and the character through a data read port. All flags except receive-edge clear through a two-step handshake: a status read that sees the flag set, then a data read. Receive-edge clears when a 1 is written to its bit. An overrun drops the late character along with its error conditions. After idle has been reported once, it stays blocked until a new character has been accepted. An interrupt request is raised whenever any flag is set whose enable bit is also set.

Top module: `uart_rx_flags`

## Requirements
- R1: When `chr_done` pulses while receive-full is clear, `chr_data` is stored and receive-full (status bit 0) sets on the next clock edge. Noise (bit 3), framing (bit 4) and parity (bit 5) take the values of `chr_noise`, `chr_frame` and `chr_parity` on that same edge.
- R2: When `chr_done` pulses while receive-full is set and is not being cleared, overrun (bit 2) sets. The stored data and the noise, framing and parity flags stay unchanged.
- R3: A data read clears exactly those of bits 0 to 5 that were set at the most recent status read since the last data read. A status read alone clears nothing, and a data read with no status read before it clears nothing.
- R4: An `idle_det` pulse sets idle (bit 1) when the idle detector is armed. Idle clears through the same status-then-data read handshake.
- R5: Once idle has set, further `idle_det` pulses have no effect until a new character has set receive-full through R1.
- R6: A falling edge on `rx_pin` sets receive-edge (bit 6) three clock edges after the pin change is sampled, but only while `rx_en` is 1. Rising edges never set it.
- R7: A status write with `wr_data` bit 6 equal to 1 clears receive-edge. A 0 in bit 6 leaves it unchanged, and no status write changes bits 0 to 5.
- R8: A flag event in the same cycle as the data read that clears that flag wins. In particular, a character that completes on a clearing data read for receive-full is stored as a normal character, without overrun.
- R9: `irq` is 1 exactly when some status bit and its matching `irq_en` bit are both 1.
- R10: After reset all flags and the data buffer are 0 and the idle detector is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; gates the receive-edge flag |
| rx_pin | input | 1 | Raw receive line, asynchronous |
| chr_done | input | 1 | One-cycle strobe: a character is complete |
| chr_data | input | DATA_W | Data of the completed character |
| chr_noise | input | 1 | Noise seen in the completed character |
| chr_frame | input | 1 | Framing error in the completed character |
| chr_parity | input | 1 | Parity error in the completed character |
| idle_det | input | 1 | One-cycle pulse: idle line detected |
| rd_status | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| wr_status | input | 1 | Status register write strobe |
| wr_data | input | 7 | Status write data, bit 6 clears receive-edge |
| irq_en | input | 7 | Per-flag interrupt enables, same bit order as status |
| status_rdata | output | 8 | Status: bit0 full, 1 idle, 2 overrun, 3 noise, 4 framing, 5 parity, 6 edge, 7 zero |
| data_rdata | output | DATA_W | Stored character data |
| irq | output | 1 | Interrupt request |

## Verification
Every strobe acts on the next clock edge. Flag, data and handshake results therefore show at the first falling clock edge after the edge that took the strobe, and `irq` follows the flags and enables with no added register. The receive-edge flag is due three rising edges after the pin change is driven: two synchronizer stages and the flag register. The bench samples that flag one edge early to confirm it is still clear, then at the due edge. A behavioural model updates on every rising edge from the same inputs and is compared with all outputs on every falling edge. Directed checks mark the cycle where each requirement's effect is due.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int NFLAG    = 7;
    localparam int F_FULL   = 0;
    localparam int F_IDLE   = 1;
    localparam int F_OVR    = 2;
    localparam int F_NOISE  = 3;
    localparam int F_FRAME  = 4;
    localparam int F_PARITY = 5;
    localparam int F_EDGE   = 6;

    typedef logic [NFLAG-1:0] flags_t;

    // bits cleared by the read handshake, bits cleared by write-one
    localparam flags_t HS_MASK  = 7'h3F;
    localparam flags_t W1C_MASK = 7'h40;
endpackage

// File: rtl/rxf_edge_det.sv
module rxf_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   last_d, last_q;

    always_comb begin
        sync_d[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
        last_d = sync_q[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign fall_o = last_q & ~sync_q[LAST];
endmodule

// File: rtl/rxf_clr_seq.sv
module rxf_clr_seq
    import rxf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rd_status,
    input  logic   rd_data,
    input  flags_t flags_i,
    output flags_t clr_o
);
    flags_t armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        if (rd_status) begin
            armed_d = flags_i & HS_MASK;
        end else if (rd_data) begin
            armed_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= '0;
        else        armed_q <= armed_d;
    end

    assign clr_o = rd_data ? armed_q : '0;

    // R3: a snapshot only ever holds handshake-clearable flags
    p_armed_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q & ~HS_MASK) == '0);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import rxf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_pin,
    input  logic              chr_done,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_noise,
    input  logic              chr_frame,
    input  logic              chr_parity,
    input  logic              idle_det,
    input  logic              rd_status,
    input  logic              rd_data,
    input  logic              wr_status,
    input  logic [NFLAG-1:0]  wr_data,
    input  logic [NFLAG-1:0]  irq_en,
    output logic [7:0]        status_rdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              irq
);
    typedef struct packed {
        flags_t            flags;
        logic              idle_arm;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;
    flags_t clr, w1c;
    logic   pin_fall, edge_evt, load, lost, idle_set;

    rxf_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (rx_pin),
        .fall_o (pin_fall)
    );

    rxf_clr_seq i_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_status (rd_status),
        .rd_data   (rd_data),
        .flags_i   (st_q.flags),
        .clr_o     (clr)
    );

    always_comb begin
        w1c      = wr_status ? (wr_data & W1C_MASK) : '0;
        edge_evt = pin_fall & rx_en;
        load     = chr_done & (~st_q.flags[F_FULL] | clr[F_FULL]);
        lost     = chr_done & ~load;
        idle_set = idle_det & st_q.idle_arm;

        st_d       = st_q;
        st_d.flags = st_q.flags & ~clr & ~w1c;
        if (load) begin
            st_d.data            = chr_data;
            st_d.flags[F_FULL]   = 1'b1;
            st_d.flags[F_NOISE]  = chr_noise;
            st_d.flags[F_FRAME]  = chr_frame;
            st_d.flags[F_PARITY] = chr_parity;
        end
        if (lost)     st_d.flags[F_OVR]  = 1'b1;
        if (idle_set) st_d.flags[F_IDLE] = 1'b1;
        if (edge_evt) st_d.flags[F_EDGE] = 1'b1;

        if (load)          st_d.idle_arm = 1'b1;
        else if (idle_set) st_d.idle_arm = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags    <= '0;
            st_q.idle_arm <= 1'b1;
            st_q.data     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_rdata = {1'b0, st_q.flags};
    assign data_rdata   = st_q.data;
    assign irq          = |(st_q.flags & irq_en);

    // R1: an error flag rises only with a strobed character carrying it
    p_noise_with_char_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags[F_NOISE]) |-> $past(chr_done && chr_noise));

    // R2: a lost character sets overrun and leaves data and errors alone
    p_overrun_keeps_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_done && st_q.flags[F_FULL] && !clr[F_FULL]) |=>
            (st_q.flags[F_OVR] && $stable(st_q.data) &&
             $stable(st_q.flags[F_PARITY:F_NOISE])));

    // R3: without a data read no handshake flag falls
    p_no_clear_without_data_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data |=> ((~st_q.flags & $past(st_q.flags) & HS_MASK) == '0));

    // R5: idle cannot rise while locked out and no character is accepted
    p_idle_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.idle_arm && !load) |=> !$rose(st_q.flags[F_IDLE]));

    // R6: receive-edge only rises while the receiver is enabled
    p_edge_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags[F_EDGE]) |-> $past(rx_en));
endmodule

// File: tb/test_uart_rx_flags.sv
`timescale 1ns/1ps
module test_uart_rx_flags;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0, rx_pin = 1'b1;
    logic          chr_done = 1'b0, chr_noise = 1'b0, chr_frame = 1'b0, chr_parity = 1'b0;
    logic [DW-1:0] chr_data = '0;
    logic          idle_det = 1'b0, rd_status = 1'b0, rd_data = 1'b0, wr_status = 1'b0;
    logic [6:0]    wr_data = '0, irq_en = '0;
    logic [7:0]    status_rdata;
    logic [DW-1:0] data_rdata;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_flags #(.DATA_W(DW)) i_uart_rx_flags (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_pin(rx_pin),
        .chr_done(chr_done), .chr_data(chr_data), .chr_noise(chr_noise),
        .chr_frame(chr_frame), .chr_parity(chr_parity), .idle_det(idle_det),
        .rd_status(rd_status), .rd_data(rd_data), .wr_status(wr_status),
        .wr_data(wr_data), .irq_en(irq_en), .status_rdata(status_rdata),
        .data_rdata(data_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [6:0]    m_flags, m_snap;
    logic [DW-1:0] m_data;
    bit            m_idle_ok;
    bit            m_hist [3];   // pin samples: newest at 0

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = '0; m_snap = '0; m_data = '0; m_idle_ok = 1'b1;
            for (int i = 0; i < 3; i++) m_hist[i] = 1'b1;
        end else begin
            logic [6:0] nxt, gone;
            bit take, fell;
            gone = rd_data ? m_snap : 7'h00;
            fell = rx_en && m_hist[2] && !m_hist[1];
            take = chr_done && (!m_flags[0] || gone[0]);
            nxt  = m_flags & ~gone;
            if (wr_status && wr_data[6]) nxt[6] = 1'b0;
            if (take) begin
                nxt[0] = 1'b1; nxt[3] = chr_noise; nxt[4] = chr_frame; nxt[5] = chr_parity;
                m_data = chr_data;
            end
            if (chr_done && !take) nxt[2] = 1'b1;
            if (idle_det && m_idle_ok) begin
                nxt[1] = 1'b1;
                m_idle_ok = 1'b0;
            end
            if (take) m_idle_ok = 1'b1;
            if (fell) nxt[6] = 1'b1;
            if (rd_status) m_snap = m_flags & 7'h3F;
            else if (rd_data) m_snap = '0;
            m_flags = nxt;
            m_hist[2] = m_hist[1]; m_hist[1] = m_hist[0]; m_hist[0] = rx_pin;
        end
    end

    function automatic string bit_req(int b);
        case (b)
            1:       return "R4";
            2:       return "R2";
            6:       return "R6";
            default: return "R1";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (status_rdata != {1'b0, m_flags}) begin
                int b;
                b = 0;
                for (int i = 6; i >= 0; i--) if (status_rdata[i] != m_flags[i]) b = i;
                errors++;
                $display("FAIL %s model status: got %02h expected %02h", bit_req(b),
                         status_rdata, {1'b0, m_flags});
            end
            checks++;
            if (data_rdata != m_data) begin
                errors++;
                $display("FAIL R1 model data: got %02h expected %02h", data_rdata, m_data);
            end
            checks++;
            if (irq != |(m_flags & irq_en)) begin
                errors++;
                $display("FAIL R9 model irq: got %0d expected %0d", irq, |(m_flags & irq_en));
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(logic [DW-1:0] d, bit nz, bit fr, bit pa, bit rd = 1'b0);
        chr_done = 1'b1; chr_data = d; chr_noise = nz; chr_frame = fr; chr_parity = pa;
        rd_data = rd;
        step();
        chr_done = 1'b0; chr_noise = 1'b0; chr_frame = 1'b0; chr_parity = 1'b0; rd_data = 1'b0;
    endtask

    task automatic pulse_idle();
        idle_det = 1'b1; step(); idle_det = 1'b0;
    endtask

    task automatic read_status();
        rd_status = 1'b1; step(); rd_status = 1'b0;
    endtask

    task automatic read_data();
        rd_data = 1'b1; step(); rd_data = 1'b0;
    endtask

    task automatic write_status(logic [6:0] v);
        wr_status = 1'b1; wr_data = v; step(); wr_status = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        chk("R10 reset status", status_rdata, 8'h00);
        chk("R10 reset data", data_rdata, 8'h00);
        chk("R10 reset irq", irq, 0);

        pulse_idle();
        chk("R10 idle armed after reset", status_rdata, 8'h02);
        read_status();
        read_data();
        chk("R4 idle cleared by handshake", status_rdata, 8'h00);
        pulse_idle();
        chk("R5 idle locked out", status_rdata, 8'h00);

        send_char(8'hA5, 1'b1, 1'b0, 1'b0);
        chk("R1 full and noise set", status_rdata, 8'h09);
        chk("R1 data stored", data_rdata, 8'hA5);
        pulse_idle();
        chk("R5 idle rearmed by character", status_rdata, 8'h0B);

        send_char(8'h3C, 1'b0, 1'b1, 1'b0);
        chk("R2 overrun, frame dropped", status_rdata, 8'h0F);
        chk("R2 data kept", data_rdata, 8'hA5);

        read_status();
        step(2);
        chk("R3 status read alone", status_rdata, 8'h0F);
        read_data();
        chk("R3 handshake clears", status_rdata, 8'h00);

        send_char(8'h5A, 1'b0, 1'b0, 1'b0);
        read_data();
        chk("R3 data read without status read", status_rdata, 8'h01);

        read_status();
        send_char(8'h77, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R8 char on clearing read", status_rdata, 8'h21);
        chk("R8 new data stored", data_rdata, 8'h77);
        read_status();
        read_data();
        chk("R3 cleared after R8 case", status_rdata, 8'h00);

        rx_en = 1'b1;
        rx_pin = 1'b0;
        step(2);
        chk("R6 edge not yet due", status_rdata, 8'h00);
        step();
        chk("R6 edge flag set", status_rdata, 8'h40);
        write_status(7'h3F);
        chk("R7 write zero to edge bit", status_rdata, 8'h40);
        irq_en = 7'h40;
        step();
        chk("R9 irq enabled flag", irq, 1);
        irq_en = 7'h01;
        step();
        chk("R9 irq disabled flag", irq, 0);
        write_status(7'h40);
        chk("R7 write one clears edge", status_rdata, 8'h00);

        rx_pin = 1'b1;
        step(4);
        chk("R6 rising edge ignored", status_rdata, 8'h00);
        rx_en = 1'b0;
        rx_pin = 1'b0;
        step(4);
        chk("R6 edge ignored when disabled", status_rdata, 8'h00);
        rx_en = 1'b1;
        rx_pin = 1'b1;
        step(3);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule